// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Sequencer

This block runs one DMA channel. It works through a table of transfer descriptors held inside the block. Each descriptor gives a source address, a destination address, a byte count, a link to the next descriptor and a small set of flags.

A trigger starts the channel at a chosen descriptor. The channel then moves data one byte per beat. For each beat it first reads the source and then writes the destination, over a single-outstanding bus master port. Every bus access has a one-cycle address phase and a data phase that the slave can stretch with a ready signal.

When a descriptor's count runs out, the channel follows that descriptor's link. A link back to the same descriptor repeats a fixed pattern. Two descriptors that point at each other form a double buffer. A longer loop forms a ring. A terminal flag ends the chain, and an endless flag makes a descriptor ignore its count.

The channel can be paused with a stall input or stopped with a cancel input. It pulses two interrupt events: one when a descriptor finishes and one when the chain ends. Software can rewrite any descriptor through a write port at any time. The channel copies a descriptor into working registers when it loads it, so a rewrite takes effect at that descriptor's next load.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `bus_valid`, `irq_done` and `irq_end` are 0.
- R2: A `trigger` pulse in idle starts the channel at descriptor `start_idx`. Each beat is a read of the source address followed by a write of the byte just read to the destination address. A descriptor performs (count field + 1) beats, so a count field of 0 moves one byte and 0xFFFF moves 65536.
- R3: Flag bit 0 set advances the source address by one after every beat, and clear holds it fixed. Flag bit 1 does the same for the destination address.
- R4: `bus_valid` marks a single-cycle address phase. The data phase is the following cycle or cycles, up to and including the first cycle with `bus_ready` high. No new address phase is issued before that.
- R5: When a descriptor finishes and its flag bit 3 (terminal) is clear, the channel loads the descriptor named by its link field. When bit 3 is set, the channel returns to idle.
- R6: A self-linked descriptor repeats from its original addresses on every pass. Two descriptors linked to each other alternate. A descriptor rewritten while the channel is busy is used with its new contents the next time it is loaded.
- R7: With flag bit 2 (endless) set, a descriptor never finishes on count. It keeps moving bytes until cancelled.
- R8: While `stall` is high, no address phase is issued. A data phase already in progress completes, and the channel keeps its position so that it resumes after `stall` falls.
- R9: A `cancel` pulse while busy returns the channel to idle without raising an interrupt. If a data phase is in progress, the channel returns to idle only after that data phase completes.
- R10: At the end of a descriptor, `irq_done` pulses for one cycle if flag bit 4 is set. At the end of a terminal descriptor, `irq_end` pulses for one cycle if flag bit 5 is set. `busy` is already low while `irq_end` is high.
- R11: A `trigger` while the channel is busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for one descriptor entry |
| cfg_idx | input | IW | Index of the entry written |
| cfg_src | input | AW | Source address of the entry |
| cfg_dst | input | AW | Destination address of the entry |
| cfg_cnt | input | CW | Beat count minus one |
| cfg_next | input | IW | Link to the next entry |
| cfg_flags | input | 6 | Bit 0 source increment, 1 destination increment, 2 endless, 3 terminal, 4 done interrupt enable, 5 end interrupt enable |
| start_idx | input | IW | First entry used on trigger |
| trigger | input | 1 | Start pulse, acted on only in idle |
| stall | input | 1 | Holds off new address phases |
| cancel | input | 1 | Abort pulse |
| busy | output | 1 | Channel active |
| irq_done | output | 1 | One-cycle pulse at the end of a descriptor |
| irq_end | output | 1 | One-cycle pulse at the end of the chain |
| bus_valid | output | 1 | Address phase |
| bus_write | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data, driven through the data phase |
| bus_rdata | input | DW | Read data, taken on the ready cycle |
| bus_ready | input | 1 | Data phase completes |

## Verification
The bench checks single-beat descriptors, fixed source and fixed destination addresses, and stretched data phases. A count that is off by one would show up as an extra or missing logged write. A slip in the address phase would change the number of address phases counted per beat.

Chains are run in self-loop, double-buffer and endless form, including a descriptor rewritten while the channel is busy. A design that reused stale working registers would write to the old buffer. A design that counted endless descriptors would stop or raise `irq_done`.

Stall, cancel during a stretched data phase, and a second trigger while busy are each aimed at one failure. Under stall, a wrong design would keep issuing accesses. On cancel, it would drop a bus transaction half-way or raise an interrupt. On the second trigger, it would restart at the other descriptor.

// File: rtl/dma_chain_seq.sv
module dma_chain_seq #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CW    = 16,
  parameter int NDESC = 32,
  parameter int IW    = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [IW-1:0] cfg_next,
  input  logic [5:0]    cfg_flags,
  input  logic [IW-1:0] start_idx,
  input  logic          trigger,
  input  logic          stall,
  input  logic          cancel,
  output logic          busy,
  output logic          irq_done,
  output logic          irq_end,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ready
);

  localparam int F_SI = 0, F_DI = 1, F_INF = 2, F_TERM = 3, F_DIE = 4, F_EIE = 5;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_RA, S_RD, S_WA, S_WD} st_t;

  logic [AW-1:0] t_src [NDESC];
  logic [AW-1:0] t_dst [NDESC];
  logic [CW-1:0] t_cnt [NDESC];
  logic [IW-1:0] t_nxt [NDESC];
  logic [5:0]    t_flg [NDESC];

  st_t           st;
  logic [IW-1:0] cur, nxt;
  logic [AW-1:0] src, dst;
  logic [CW-1:0] rem;
  logic [5:0]    flg;
  logic [DW-1:0] dat;
  logic          cxl;

  wire abort     = cancel | cxl;
  wire last_beat = !flg[F_INF] && (rem == '0);

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      t_src[cfg_idx] <= cfg_src;
      t_dst[cfg_idx] <= cfg_dst;
      t_cnt[cfg_idx] <= cfg_cnt;
      t_nxt[cfg_idx] <= cfg_next;
      t_flg[cfg_idx] <= cfg_flags;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur      <= '0;
      nxt      <= '0;
      src      <= '0;
      dst      <= '0;
      rem      <= '0;
      flg      <= '0;
      dat      <= '0;
      cxl      <= 1'b0;
      irq_done <= 1'b0;
      irq_end  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_end  <= 1'b0;
      case (st)
        S_IDLE: begin
          cxl <= 1'b0;
          if (trigger && !cancel) begin
            cur <= start_idx;
            st  <= S_LOAD;
          end
        end
        S_LOAD: begin
          if (abort) st <= S_IDLE;
          else begin
            src <= t_src[cur];
            dst <= t_dst[cur];
            rem <= t_cnt[cur];
            nxt <= t_nxt[cur];
            flg <= t_flg[cur];
            st  <= S_RA;
          end
        end
        S_RA: begin
          if (abort) st <= S_IDLE;
          else if (!stall) st <= S_RD;
        end
        S_RD: begin
          if (cancel) cxl <= 1'b1;
          if (bus_ready) begin
            dat <= bus_rdata;
            st  <= abort ? S_IDLE : S_WA;
          end
        end
        S_WA: begin
          if (abort) st <= S_IDLE;
          else if (!stall) st <= S_WD;
        end
        S_WD: begin
          if (cancel) cxl <= 1'b1;
          if (bus_ready) begin
            if (abort) st <= S_IDLE;
            else begin
              if (flg[F_SI]) src <= src + AW'(1);
              if (flg[F_DI]) dst <= dst + AW'(1);
              if (last_beat) begin
                irq_done <= flg[F_DIE];
                if (flg[F_TERM]) begin
                  irq_end <= flg[F_EIE];
                  st      <= S_IDLE;
                end else begin
                  cur <= nxt;
                  st  <= S_LOAD;
                end
              end else begin
                if (!flg[F_INF]) rem <= rem - CW'(1);
                st <= S_RA;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign bus_valid = (st == S_RA || st == S_WA) && !stall && !abort;
  assign bus_write = (st == S_WA) || (st == S_WD);
  assign bus_addr  = bus_write ? dst : src;
  assign bus_wdata = dat;

endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic bus_valid,
  input logic bus_ready,
  input logic stall,
  input logic irq_done,
  input logic irq_end
);

  logic dph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dph <= 1'b0;
    else if (bus_valid) dph <= 1'b1;
    else if (bus_ready) dph <= 1'b0;
  end

  // R4
  single_addr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> !bus_valid);

  // R4
  no_issue_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !dph);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !bus_valid);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done);

  // R10
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |=> !irq_end);

  // R10
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> !busy);

  // R9
  idle_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dph && !bus_valid));

endmodule

bind dma_chain_seq dma_chain_seq_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .bus_valid (bus_valid),
  .bus_ready (bus_ready),
  .stall     (stall),
  .irq_done  (irq_done),
  .irq_end   (irq_end)
);

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;

  localparam int AW = 16, DW = 8, CW = 16, NDESC = 32, IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0, cfg_next = '0, start_idx = '0;
  logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
  logic [CW-1:0] cfg_cnt = '0;
  logic [5:0] cfg_flags = '0;
  logic trigger = 1'b0, stall = 1'b0, cancel = 1'b0;
  logic busy, irq_done, irq_end, bus_valid, bus_write, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #2.5 clk = ~clk;

  dma_chain_seq #(.AW(AW), .DW(DW), .CW(CW), .NDESC(NDESC), .IW(IW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .cfg_next(cfg_next), .cfg_flags(cfg_flags), .start_idx(start_idx),
    .trigger(trigger), .stall(stall), .cancel(cancel), .busy(busy),
    .irq_done(irq_done), .irq_end(irq_end), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready));

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // bus slave model: source bytes follow pat(), writes are logged
  int waits = 0;
  logic ph_act = 1'b0, ph_wr = 1'b0;
  logic [AW-1:0] ph_addr = '0;
  int wcnt = 0, wn = 0, vcount = 0, nd = 0, ne = 0, cyc = 0;
  logic [AW-1:0] wla [0:1023];
  logic [DW-1:0] wld [0:1023];

  assign bus_ready = ph_act && (wcnt == 0);
  assign bus_rdata = pat(ph_addr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ph_act && bus_ready) begin
      ph_act <= 1'b0;
      if (ph_wr) begin
        wla[wn % 1024] <= ph_addr;
        wld[wn % 1024] <= bus_wdata;
        wn <= wn + 1;
      end
    end else if (ph_act) wcnt <= wcnt - 1;
    if (bus_valid) begin
      ph_act  <= 1'b1;
      ph_wr   <= bus_write;
      ph_addr <= bus_addr;
      wcnt    <= waits;
      vcount  <= vcount + 1;
    end
    if (irq_done) nd <= nd + 1;
    if (irq_end)  ne <= ne + 1;
  end

  int nchk = 0, nerr = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic prog(input int idx, input int s, input int d, input int c,
                      input int n, input logic [5:0] f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_src = AW'(s); cfg_dst = AW'(d);
    cfg_cnt = CW'(c); cfg_next = IW'(n); cfg_flags = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_trig(input int idx);
    @(negedge clk);
    start_idx = IW'(idx); trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  task automatic pulse_cancel();
    @(negedge clk);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_writes(input int target);
    while (wn < target) @(negedge clk);
  endtask

  // vector: src[27:20] dst[19:12] cnt[11:4] src_inc[3] dst_inc[2] waits[1:0]
  localparam int NV = 5;
  localparam logic [27:0] VECS [0:NV-1] = '{
    {8'h10, 8'h80, 8'd3, 1'b1, 1'b1, 2'd0},
    {8'h20, 8'h90, 8'd0, 1'b1, 1'b1, 2'd1},
    {8'h30, 8'hA0, 8'd2, 1'b0, 1'b1, 2'd2},
    {8'h40, 8'hB0, 8'd4, 1'b1, 1'b0, 2'd0},
    {8'h48, 8'hC0, 8'd1, 1'b1, 1'b1, 2'd3}
  };

  initial begin : watchdog
    while (cyc < 100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin : main
    int b, bv, bd, be, s, d, c, n;
    bit si, di;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !bus_valid && !irq_done && !irq_end, "R1 reset",
        {busy, bus_valid, irq_done, irq_end}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_valid && !irq_done && !irq_end, "R1 after reset",
        {busy, bus_valid, irq_done, irq_end}, 0);

    // R2 R3 R4 R10: single terminal descriptors
    for (int v = 0; v < NV; v++) begin
      s = int'(VECS[v][27:20]); d = int'(VECS[v][19:12]); c = int'(VECS[v][11:4]);
      si = VECS[v][3]; di = VECS[v][2]; waits = int'(VECS[v][1:0]);
      prog(0, s, d, c, 0, {4'b1110, di, si});
      b = wn; bv = vcount; bd = nd; be = ne;
      pulse_trig(0);
      wait_idle();
      chk(wn - b == c + 1, "R2 beat count", wn - b, c + 1);
      for (int k = 0; k <= c; k++) begin
        chk(wla[(b + k) % 1024] == AW'(d + (di ? k : 0)), "R3 write address",
            int'(wla[(b + k) % 1024]), d + (di ? k : 0));
        chk(wld[(b + k) % 1024] == pat(16'(s + (si ? k : 0))), "R2 write data",
            int'(wld[(b + k) % 1024]), int'(pat(16'(s + (si ? k : 0)))));
      end
      chk(vcount - bv == 2 * (c + 1), "R4 address phases", vcount - bv, 2 * (c + 1));
      chk(nd - bd == 1 && ne - be == 1, "R10 irq counts", (nd - bd) * 16 + (ne - be), 17);
    end
    waits = 0;

    // R5 R10: two-entry chain, done interrupt disabled on the first
    prog(1, 'h00, 'h80, 1, 2, 6'b000011);
    prog(2, 'h08, 'h88, 0, 0, 6'b111011);
    b = wn; bd = nd; be = ne;
    pulse_trig(1);
    wait_idle();
    chk(wn - b == 3, "R5 chain length", wn - b, 3);
    chk(wla[(b + 2) % 1024] == 16'h88, "R5 follows link", int'(wla[(b + 2) % 1024]), 'h88);
    chk(wld[(b + 2) % 1024] == pat(16'h08), "R5 linked data",
        int'(wld[(b + 2) % 1024]), int'(pat(16'h08)));
    chk(nd - bd == 1, "R10 done enable", nd - bd, 1);
    chk(ne - be == 1, "R10 end pulse", ne - be, 1);

    // R6 self-linked auto-repeat
    prog(3, 'h10, 'hD0, 1, 3, 6'b000011);
    b = wn;
    pulse_trig(3);
    wait_writes(b + 5);
    pulse_cancel();
    wait_idle();
    for (int k = 0; k < 4; k++)
      chk(wla[(b + k) % 1024] == AW'('hD0 + (k % 2)), "R6 auto-repeat",
          int'(wla[(b + k) % 1024]), 'hD0 + (k % 2));

    // R6 ping-pong with live rewrite
    prog(4, 'h20, 'hE0, 1, 5, 6'b000011);
    prog(5, 'h28, 'hE8, 1, 4, 6'b000011);
    b = wn;
    pulse_trig(4);
    wait_writes(b + 1);
    prog(4, 'h20, 'hF0, 1, 5, 6'b000011);
    wait_writes(b + 6);
    pulse_cancel();
    wait_idle();
    chk(wla[(b + 2) % 1024] == 16'hE8, "R6 ping-pong partner", int'(wla[(b + 2) % 1024]), 'hE8);
    chk(wla[(b + 4) % 1024] == 16'hF0, "R6 rewrite used", int'(wla[(b + 4) % 1024]), 'hF0);
    chk(wla[(b + 5) % 1024] == 16'hF1, "R6 rewrite used", int'(wla[(b + 5) % 1024]), 'hF1);

    // R7 endless
    prog(6, 'h30, 'h80, 0, 6, 6'b111111);
    b = wn; bd = nd;
    pulse_trig(6);
    wait_writes(b + 5);
    chk(busy, "R7 still busy", busy, 1);
    chk(nd == bd, "R7 no done", nd - bd, 0);
    chk(wla[(b + 4) % 1024] == 16'h84, "R7 keeps moving", int'(wla[(b + 4) % 1024]), 'h84);
    pulse_cancel();
    wait_idle();
    chk(!busy, "R9 cancel endless", busy, 0);

    // R8 stall
    prog(0, 'h00, 'h80, 7, 0, 6'b111011);
    b = wn;
    pulse_trig(0);
    wait_writes(b + 2);
    @(negedge clk); stall = 1'b1;
    repeat (3) @(negedge clk);
    bv = vcount; n = wn;
    repeat (20) @(negedge clk);
    chk(vcount == bv && wn == n, "R8 no access under stall", vcount - bv, 0);
    chk(busy, "R8 state held", busy, 1);
    stall = 1'b0;
    wait_idle();
    chk(wn - b == 8, "R8 resumes", wn - b, 8);
    chk(wla[(b + 7) % 1024] == 16'h87, "R8 last address", int'(wla[(b + 7) % 1024]), 'h87);

    // R9 cancel inside a stretched data phase
    waits = 3;
    b = wn; bd = nd; be = ne;
    pulse_trig(0);
    wait_writes(b + 1);
    while (!(ph_act && !bus_ready)) @(negedge clk);
    cancel = 1'b1;
    @(negedge clk);
    cancel = 1'b0;
    while (busy) @(negedge clk);
    chk(!ph_act, "R9 data phase finished", ph_act, 0);
    n = wn;
    repeat (10) @(negedge clk);
    chk(wn == n && wn - b < 8, "R9 stopped", wn - b, n - b);
    chk(nd == bd && ne == be, "R9 no interrupt", (nd - bd) + (ne - be), 0);
    waits = 0;

    // R11 trigger while busy
    prog(0, 'h00, 'h80, 3, 0, 6'b111011);
    b = wn; bd = nd;
    pulse_trig(0);
    wait_writes(b + 1);
    pulse_trig(2);
    wait_idle();
    chk(wn - b == 4, "R11 no restart", wn - b, 4);
    chk(wla[(b + 3) % 1024] == 16'h83, "R11 same descriptor", int'(wla[(b + 3) % 1024]), 'h83);
    chk(nd - bd == 1, "R11 one done", nd - bd, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule